// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Timer

This block is a watchdog timer that does not simply fire once when it runs out. Each time its programmed period elapses without a keepalive, it moves one stage further. The first expiry raises an interrupt level. The second adds a non-maskable interrupt level. The third issues a one-cycle soft-reset request. Software programs it with one configuration write that carries a 16-bit length and a 2-bit mode. It keeps the block alive with a poke strobe. It can read back the current stage and the live count at any time.

The 16-bit length forms the upper bits of a 24-bit down-counter, and the lower eight bits of that counter start at zero. An 8-bit prescaler steps the counter once every 256 clocks, so the longest period is close to 2^32 clocks. The mode field limits how far the escalation may go. An interrupt handler can test bit 1 of the stage readback to tell a watchdog NMI from an NMI raised by some other source.

All pins are plain control and status. No data streams pass through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `esc_wdog`

## Requirements
- R1: A configuration write (`cfg_we`) loads the mode and the length, and the count readback becomes `{cfg_len, 8'h00}` after one cycle: the length sits in bits 23:8 and bits 7:0 are zero. The write also returns the stage to idle (0) and restarts the prescaler. Mode 0 loads the count in the same way.
- R2: While enabled, the count drops by exactly one every 256 clocks. The first step comes 256 clocks after the configuration write or poke that loaded it.
- R3: An expiry happens on a prescaler step while the count is 0. On that step the count reloads `{length, 8'h00}`. With length L, an expiry therefore comes 256*(256*L+1) clocks after a load.
- R4: The first expiry moves the stage from 0 (idle) to 1 (interrupt) and raises `irq_o`.
- R5: The next expiry moves the stage to 2 (NMI) and raises `nmi_o`, while `irq_o` stays high. Bit 1 of the stage readback is set in stages 2 and 3.
- R6: In mode 3, the expiry after stage 2 shows stage 3 for exactly one cycle and pulses `rst_req_o` in that same cycle. The stage then goes back to idle with all outputs low, and it stays there with no further expiry until a configuration write or a poke.
- R7: Mode 1 stops escalating at stage 1, and mode 2 stops at stage 2. Neither mode ever asserts `rst_req_o`.
- R8: Mode 0 disables the block. The count is frozen, the stage stays idle, and all three outputs stay low.
- R9: A poke returns the stage to idle, drops `irq_o` and `nmi_o`, reloads the count from the stored length and restarts the prescaler. This also holds after a reset request.
- R10: A configuration write wins over a poke in the same cycle, so the new length is the one loaded. A poke wins over an expiry in the same cycle, so the stage stays idle.
- R11: With length 0 and the block enabled, the first expiry comes 256 clocks after the load.
- R12: After `rst_n` is released, the stage is 0, the count is 0, the mode is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 16 | Length, upper 16 bits of the 24-bit count |
| cfg_mode | input | 2 | 0 off, 1 interrupt only, 2 up to NMI, 3 up to reset |
| poke | input | 1 | Keepalive strobe |
| stage_o | output | 2 | Current stage: 0 idle, 1 interrupt, 2 NMI, 3 reset |
| count_o | output | 24 | Live count |
| irq_o | output | 1 | Interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
The escalation is run with length 0 in each of the three enabled modes. Each stage is checked one clock before its expiry edge and again on that edge, which separates an off-by-one in the prescaler from a wrong stage limit per mode. A length of 1 checks the full 256*(256*L+1) period and the reload. A nonzero length with mode 0 shows that the block loads the count but does not run. Pokes placed in the idle-after-reset state and exactly on an expiry edge, and a poke that coincides with a configuration write, check the R10 priorities at the readback pins.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;
  localparam int LEN_W = 16;
  localparam int PRE_W = 8;
  localparam int CNT_W = LEN_W + PRE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_RST  = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_IRQ  = 2'd1,
    MD_NMI  = 2'd2,
    MD_FULL = 2'd3
  } mode_e;
endpackage

// File: rtl/esc_wdog_prescale.sv
module esc_wdog_prescale #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clear)  pre_q <= '0;
    else if (run)    pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/esc_wdog_counter.sv
module esc_wdog_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = step && at_zero && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (step) begin
      if (at_zero)    cnt_q <= reload_val;
      else            cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/esc_wdog_stage.sv
module esc_wdog_stage
  import esc_wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   expire,
  input  mode_e  mode,
  output stage_e stage,
  output logic   spent
);
  stage_e stage_q;
  logic   spent_q;
  stage_e stage_up;

  always_comb begin
    stage_up = stage_q;
    unique case (stage_q)
      ST_IDLE: if (mode != MD_OFF)                  stage_up = ST_IRQ;
      ST_IRQ:  if (mode == MD_NMI || mode == MD_FULL) stage_up = ST_NMI;
      ST_NMI:  if (mode == MD_FULL)                 stage_up = ST_RST;
      default:                                      stage_up = stage_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      spent_q <= 1'b0;
    end else if (restart) begin
      stage_q <= ST_IDLE;
      spent_q <= 1'b0;
    end else if (stage_q == ST_RST) begin
      stage_q <= ST_IDLE;
      spent_q <= 1'b1;
    end else if (expire) begin
      stage_q <= stage_up;
    end
  end

  assign stage = stage_q;
  assign spent = spent_q;
endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_mode,
  input  logic             poke,
  output logic [1:0]       stage_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  mode_e            mode_q;
  logic [LEN_W-1:0] len_q;
  logic             restart;
  logic             run;
  logic             tick;
  logic             expire;
  logic             spent;
  stage_e           stage;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      len_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_e'(cfg_mode);
      len_q  <= cfg_len;
    end
  end

  assign restart    = cfg_we || poke;
  assign run        = (mode_q != MD_OFF) && !spent;
  assign reload_val = {len_q, {PRE_W{1'b0}}};
  assign load_val   = cfg_we ? {cfg_len, {PRE_W{1'b0}}} : reload_val;

  esc_wdog_prescale #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .run   (run),
    .tick  (tick)
  );

  esc_wdog_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (restart),
    .load_val   (load_val),
    .reload_val (reload_val),
    .step       (tick),
    .count      (count_o),
    .expire     (expire)
  );

  esc_wdog_stage u_stg (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expire  (expire),
    .mode    (mode_q),
    .stage   (stage),
    .spent   (spent)
  );

  assign stage_o   = stage;
  assign irq_o     = (stage != ST_IDLE);
  assign nmi_o     = stage[1];
  assign rst_req_o = (stage == ST_RST);
endmodule

// File: rtl/esc_wdog_chk.sv
module esc_wdog_chk
  import esc_wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [LEN_W-1:0] cfg_len,
  input logic             poke,
  input logic [1:0]       stage_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             rst_req_o,
  input logic [1:0]       mode_q
);
  // R1
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (count_o == {$past(cfg_len), {PRE_W{1'b0}}}) && (stage_o == 2'd0));

  // R9
  poke_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poke && !cfg_we) |=> (stage_o == 2'd0) && !irq_o && !nmi_o);

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o && (stage_o == 2'd0));

  // R7
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (mode_q == 2'd3));

  // R5
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !poke && stage_o != 2'd0 && stage_o != 2'd3)
      |=> (stage_o == $past(stage_o)) || (stage_o == $past(stage_o) + 2'd1));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !poke && mode_q == 2'd0) |=> $stable(count_o) && (stage_o == 2'd0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !poke && count_o != '0)
      |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));
endmodule

bind esc_wdog esc_wdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_len   (cfg_len),
  .poke      (poke),
  .stage_o   (stage_o),
  .count_o   (count_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .rst_req_o (rst_req_o),
  .mode_q    (mode_q)
);

// File: tb/esc_wdog_tb.sv
module esc_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [1:0]  cfg_mode = '0;
  logic        poke = 1'b0;
  logic [1:0]  stage_o;
  logic [23:0] count_o;
  logic        irq_o, nmi_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  int rst_pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  esc_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .stage_o(stage_o), .count_o(count_o),
    .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (rst_n && rst_req_o) rst_pulses++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_stage(input string req, input logic [1:0] st);
    chk(req, "stage", 32'(stage_o), 32'(st));
    chk(req, "irq", 32'(irq_o), 32'(st != 2'd0));
    chk(req, "nmi", 32'(nmi_o), 32'(st[1]));
    chk(req, "rst_req", 32'(rst_req_o), 32'(st == 2'd3));
  endtask

  // leaves the bench just after the loading edge
  task automatic do_cfg(input logic [15:0] len, input logic [1:0] md, input bit with_poke);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = len; cfg_mode = md; poke = with_poke;
    @(negedge clk);
    cfg_we = 1'b0; poke = 1'b0;
  endtask

  task automatic do_poke();
    @(negedge clk); poke = 1'b1;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12", "count", 32'(count_o), 32'h0);
    chk_stage("R12", 2'd0);
  endtask

  task automatic t_load_and_step();
    do_cfg(16'h1234, 2'd3, 1'b0);
    chk("R1", "count", 32'(count_o), 32'h123400);
    chk_stage("R1", 2'd0);
    wait_edges(255);
    chk("R2", "count before step", 32'(count_o), 32'h123400);
    wait_edges(1);
    chk("R2", "count first step", 32'(count_o), 32'h1233FF);
    wait_edges(256);
    chk("R2", "count second step", 32'(count_o), 32'h1233FE);
  endtask

  task automatic t_full_escalation();
    rst_pulses = 0;
    do_cfg(16'h0000, 2'd3, 1'b0);
    wait_edges(255);
    chk_stage("R11", 2'd0);
    wait_edges(1);
    chk_stage("R4", 2'd1);
    chk("R11", "count after reload", 32'(count_o), 32'h0);
    wait_edges(256);
    chk_stage("R5", 2'd2);
    wait_edges(255);
    chk_stage("R5", 2'd2);
    wait_edges(1);
    chk_stage("R6", 2'd3);
    wait_edges(1);
    chk_stage("R6", 2'd0);
    wait_edges(800);
    chk_stage("R6", 2'd0);
    chk("R6", "reset pulses", 32'(rst_pulses), 32'd1);
    do_poke();
    wait_edges(255);
    chk_stage("R9", 2'd0);
    wait_edges(1);
    chk_stage("R9", 2'd1);
  endtask

  task automatic t_mode_limits();
    rst_pulses = 0;
    do_cfg(16'h0000, 2'd1, 1'b0);
    wait_edges(256);
    chk_stage("R7", 2'd1);
    wait_edges(512);
    chk_stage("R7", 2'd1);
    do_cfg(16'h0000, 2'd2, 1'b0);
    chk_stage("R1", 2'd0);
    wait_edges(512);
    chk_stage("R7", 2'd2);
    wait_edges(768);
    chk_stage("R7", 2'd2);
    chk("R7", "reset pulses", 32'(rst_pulses), 32'd0);
  endtask

  task automatic t_disabled();
    do_cfg(16'h0005, 2'd0, 1'b0);
    chk("R8", "count loaded", 32'(count_o), 32'h000500);
    wait_edges(1000);
    chk("R8", "count frozen", 32'(count_o), 32'h000500);
    chk_stage("R8", 2'd0);
  endtask

  task automatic t_poke_mid();
    do_cfg(16'h0000, 2'd3, 1'b0);
    wait_edges(512);
    chk_stage("R5", 2'd2);
    do_poke();
    chk_stage("R9", 2'd0);
    wait_edges(255);
    chk_stage("R9", 2'd0);
    wait_edges(1);
    chk_stage("R9", 2'd1);
  endtask

  task automatic t_priority();
    do_cfg(16'h0003, 2'd3, 1'b0);
    wait_edges(10);
    do_cfg(16'h0010, 2'd1, 1'b1);
    chk("R10", "cfg beats poke", 32'(count_o), 32'h001000);
    do_cfg(16'h0000, 2'd3, 1'b0);
    wait_edges(254);
    do_poke();
    chk_stage("R10", 2'd0);
    wait_edges(255);
    chk_stage("R10", 2'd0);
    wait_edges(1);
    chk_stage("R10", 2'd1);
  endtask

  task automatic t_long_period();
    do_cfg(16'h0001, 2'd3, 1'b0);
    chk("R3", "count", 32'(count_o), 32'h000100);
    wait_edges(65791);
    chk_stage("R3", 2'd0);
    wait_edges(1);
    chk_stage("R3", 2'd1);
    chk("R3", "count reload", 32'(count_o), 32'h000100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_step();
    t_full_escalation();
    t_mode_limits();
    t_disabled();
    t_poke_mid();
    t_priority();
    t_long_period();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule